// File: doc/BRIEF.md
# Power-Up and Wake Reset Sequencer

This block takes a battery-powered device from the moment a supply appears to the point where the main processor may start booting. When an adapter or a battery is detected it first enables the always-on standby supply. It then powers the mode controller and starts the main crystal. A hardware reset follows, and the crystal is stopped while that reset is held. An internal controller reset comes next, after which the crystal is restarted. A short initialisation period leads into a sleep state where only the 32.768 kHz clock runs.

A debounced press of the power key wakes the block. The crystal is started again, and once it is ready the processor reset is held for a fixed number of main-clock cycles and then released. At that point boot begins.

The sequencer runs on one free-running clock `clk`. It receives two enable strobes: `slow_tick` (one cycle per 32.768 kHz period) and `main_tick` (one cycle per main-crystal cycle while the crystal runs). Every wait for the crystal is bounded by a timeout counted in slow ticks, and an expired timeout parks the block in a fault state. Losing both supplies returns it to power-off from any state. All inputs are synchronous to `clk`, and `rst_n` is released synchronously by the reset logic upstream.

Top module: `pwr_wake_seq`

## Requirements
- R1: While `rst_n` is low, and for as long as neither `adapter_ok` nor `battery_ok` is high, every output is low: the standby, controller-power and oscillator enables are off, `hw_rst_n`, `ctrl_rst_n` and `dsp_rst_n` are asserted (low), and `asleep`, `boot_go` and `fault` are 0.
- R2: Either supply input going high raises `standby_en` in the next cycle. `ctrl_pwr_en` and `osc_en` rise together on the STBY_TICKS-th slow tick counted after that, so the gap between the two rises is more than (STBY_TICKS-1) and at most STBY_TICKS slow-tick periods.
- R3: The first crystal start ends on the first slow tick at which `osc_ready` is sampled high. `hw_rst_n` is then driven low and `osc_en` low in the same cycle.
- R4: `hw_rst_n` stays low for exactly HWRST_TICKS slow ticks with the crystal stopped. Then `hw_rst_n` rises while `ctrl_rst_n` stays low for exactly INTRST_TICKS slow ticks, still with the crystal stopped.
- R5: At the end of the internal reset, `osc_en` rises and `ctrl_rst_n` is released in the same cycle. After `osc_ready` is sampled on a slow tick, INIT_TICKS slow ticks pass and the block enters sleep: `asleep` is 1 and `osc_en` is 0.
- R6: In sleep, `pwr_key` is sampled only on slow ticks. A wake is accepted only after KEY_SAMPLES (32) consecutive high samples, and any low sample restarts the count. The key has no effect outside sleep.
- R7: On an accepted wake, `asleep` falls and `osc_en` rises in the same cycle. `dsp_rst_n` stays low while the crystal is awaited.
- R8: Counting from the slow tick at which `osc_ready` is first seen high after the wake, `dsp_rst_n` stays low for exactly DSP_CYCLES `main_tick` cycles. It is then released together with `boot_go`.
- R9: If `osc_ready` is not seen by the OSC_TMO_TICKS-th slow tick of any crystal wait, `fault` rises with `osc_en` low and `ctrl_rst_n` and `dsp_rst_n` asserted. The fault holds, whatever `osc_ready` and `pwr_key` do, until both supplies are lost.
- R10: When `adapter_ok` and `battery_ok` are both low, every output returns to the R1 values in the next cycle, from any state. Losing only one of the two supplies has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| main_tick | input | 1 | One-cycle strobe per main-crystal cycle |
| adapter_ok | input | 1 | Adapter present |
| battery_ok | input | 1 | Battery present |
| pwr_key | input | 1 | Raw power-key level, high when pressed |
| osc_ready | input | 1 | Main crystal stable |
| standby_en | output | 1 | Always-on standby supply enable |
| ctrl_pwr_en | output | 1 | Mode controller power enable |
| osc_en | output | 1 | Main crystal enable |
| hw_rst_n | output | 1 | Hardware reset, active low |
| ctrl_rst_n | output | 1 | Internal controller reset, active low |
| dsp_rst_n | output | 1 | Main processor reset, active low |
| asleep | output | 1 | Sleep state, only the slow clock in use |
| boot_go | output | 1 | Processor reset released, boot may start |
| fault | output | 1 | Crystal timeout, sequence parked |

## Verification
The start-up walk is run once with the crystal ready at once, which pins each phase to an exact length in cycles. It is then run with random crystal delays and with either supply alone or both together, which separates waiting on the ready input from plain timed phases. Key patterns include a directed 31-high run broken by one low sample, plus random high runs split by single lows. These separate a true consecutive count from a cumulative one, and set the exact tick of the wake. Crystal timeouts at start-up and at wake, and supply losses at random points, show the fault latch and the return to power-off.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_STBY,
    ST_OSC_ON,
    ST_HWRST,
    ST_INTRST,
    ST_OSC_RE,
    ST_INIT,
    ST_SLEEP,
    ST_WAKE,
    ST_DSPRST,
    ST_RUN,
    ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic standby_en;
    logic ctrl_pwr_en;
    logic osc_en;
    logic hw_rst_n;
    logic ctrl_rst_n;
    logic dsp_rst_n;
    logic asleep;
    logic boot_go;
    logic fault;
  } seq_out_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_tick_timer.sv
// Counts enable strobes since the last clear; saturates at all ones.
module seq_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (step && (cnt != {W{1'b1}})) begin
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/seq_key_filter.sv
// Accepts the key once it has been sampled high on SAMPLES consecutive ticks.
module seq_key_filter #(
  parameter int SAMPLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sample,
  input  logic key,
  output logic accepted
);

  localparam int KW = $clog2(SAMPLES + 1);
  localparam logic [KW-1:0] FULL = KW'(SAMPLES);

  logic [KW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (!en) begin
      run_d = '0;
    end else if (sample) begin
      if (!key) begin
        run_d = '0;
      end else if (run_q != FULL) begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  assign accepted = en && (run_q == FULL);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
#(
  parameter int TW            = 8,
  parameter int DW            = 11,
  parameter int STBY_TICKS    = 8,
  parameter int OSC_TMO_TICKS = 64,
  parameter int HWRST_TICKS   = 16,
  parameter int INTRST_TICKS  = 4,
  parameter int INIT_TICKS    = 8,
  parameter int DSP_CYCLES    = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          slow_tick,
  input  logic          main_tick,
  input  logic          osc_ready,
  input  logic          key_ok,
  input  logic [TW-1:0] slow_cnt,
  input  logic [DW-1:0] main_cnt,
  output seq_state_e    state_q,
  output logic          restart
);

  localparam logic [TW-1:0] STBY_LAST   = TW'(STBY_TICKS - 1);
  localparam logic [TW-1:0] TMO_LAST    = TW'(OSC_TMO_TICKS - 1);
  localparam logic [TW-1:0] HWRST_LAST  = TW'(HWRST_TICKS - 1);
  localparam logic [TW-1:0] INTRST_LAST = TW'(INTRST_TICKS - 1);
  localparam logic [TW-1:0] INIT_LAST   = TW'(INIT_TICKS - 1);
  localparam logic [DW-1:0] DSP_LAST    = DW'(DSP_CYCLES - 1);

  seq_state_e state_d;

  // Shared crystal wait: ready wins over a timeout on the same tick.
  function automatic seq_state_e osc_wait(input seq_state_e cur, input seq_state_e nxt,
                                          input logic tick, input logic rdy,
                                          input logic [TW-1:0] cnt);
    seq_state_e r;
    r = cur;
    if (tick) begin
      if (rdy) begin
        r = nxt;
      end else if (cnt == TMO_LAST) begin
        r = ST_FAULT;
      end
    end
    return r;
  endfunction

  always_comb begin
    state_d = state_q;
    if (!pwr_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_STBY;
        ST_STBY:   if (slow_tick && slow_cnt == STBY_LAST) state_d = ST_OSC_ON;
        ST_OSC_ON: state_d = osc_wait(ST_OSC_ON, ST_HWRST, slow_tick, osc_ready, slow_cnt);
        ST_HWRST:  if (slow_tick && slow_cnt == HWRST_LAST) state_d = ST_INTRST;
        ST_INTRST: if (slow_tick && slow_cnt == INTRST_LAST) state_d = ST_OSC_RE;
        ST_OSC_RE: state_d = osc_wait(ST_OSC_RE, ST_INIT, slow_tick, osc_ready, slow_cnt);
        ST_INIT:   if (slow_tick && slow_cnt == INIT_LAST) state_d = ST_SLEEP;
        ST_SLEEP:  if (key_ok) state_d = ST_WAKE;
        ST_WAKE:   state_d = osc_wait(ST_WAKE, ST_DSPRST, slow_tick, osc_ready, slow_cnt);
        ST_DSPRST: if (main_tick && main_cnt == DSP_LAST) state_d = ST_RUN;
        ST_RUN:    state_d = ST_RUN;
        ST_FAULT:  state_d = ST_FAULT;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/seq_outdec.sv
module seq_outdec
  import seq_pkg::*;
(
  input  seq_state_e state,
  output seq_out_t   outs
);

  always_comb begin
    outs = '0;
    unique case (state)
      ST_OFF: begin
        outs = '0;
      end
      ST_STBY: begin
        outs.standby_en = 1'b1;
      end
      ST_OSC_ON: begin
        outs.standby_en  = 1'b1;
        outs.ctrl_pwr_en = 1'b1;
        outs.osc_en      = 1'b1;
        outs.hw_rst_n    = 1'b1;
      end
      ST_HWRST, ST_INTRST: begin
        outs.standby_en  = 1'b1;
        outs.ctrl_pwr_en = 1'b1;
        outs.hw_rst_n    = (state == ST_INTRST);
      end
      ST_OSC_RE, ST_INIT, ST_WAKE, ST_DSPRST: begin
        outs.standby_en  = 1'b1;
        outs.ctrl_pwr_en = 1'b1;
        outs.osc_en      = 1'b1;
        outs.hw_rst_n    = 1'b1;
        outs.ctrl_rst_n  = 1'b1;
      end
      ST_SLEEP: begin
        outs.standby_en  = 1'b1;
        outs.ctrl_pwr_en = 1'b1;
        outs.hw_rst_n    = 1'b1;
        outs.ctrl_rst_n  = 1'b1;
        outs.asleep      = 1'b1;
      end
      ST_RUN: begin
        outs.standby_en  = 1'b1;
        outs.ctrl_pwr_en = 1'b1;
        outs.osc_en      = 1'b1;
        outs.hw_rst_n    = 1'b1;
        outs.ctrl_rst_n  = 1'b1;
        outs.dsp_rst_n   = 1'b1;
        outs.boot_go     = 1'b1;
      end
      ST_FAULT: begin
        outs.standby_en  = 1'b1;
        outs.ctrl_pwr_en = 1'b1;
        outs.hw_rst_n    = 1'b1;
        outs.fault       = 1'b1;
      end
      default: outs = '0;
    endcase
  end

endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
  import seq_pkg::*;
#(
  parameter int STBY_TICKS    = 8,
  parameter int OSC_TMO_TICKS = 64,
  parameter int HWRST_TICKS   = 16,
  parameter int INTRST_TICKS  = 4,
  parameter int INIT_TICKS    = 8,
  parameter int KEY_SAMPLES   = 32,
  parameter int DSP_CYCLES    = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic main_tick,
  input  logic adapter_ok,
  input  logic battery_ok,
  input  logic pwr_key,
  input  logic osc_ready,
  output logic standby_en,
  output logic ctrl_pwr_en,
  output logic osc_en,
  output logic hw_rst_n,
  output logic ctrl_rst_n,
  output logic dsp_rst_n,
  output logic asleep,
  output logic boot_go,
  output logic fault
);

  localparam int SLOW_MAX = imax(imax(imax(STBY_TICKS, OSC_TMO_TICKS),
                                      imax(HWRST_TICKS, INTRST_TICKS)), INIT_TICKS);
  localparam int TW = $clog2(SLOW_MAX) + 1;
  localparam int DW = $clog2(DSP_CYCLES) + 1;

  seq_state_e    state_q;
  seq_out_t      outs;
  logic          restart;
  logic          key_accept;
  logic          pwr_ok;
  logic [TW-1:0] slow_cnt;
  logic [DW-1:0] main_cnt;

  assign pwr_ok = adapter_ok | battery_ok;

  seq_tick_timer #(.W(TW)) u_slow_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .step  (slow_tick),
    .cnt   (slow_cnt)
  );

  seq_tick_timer #(.W(DW)) u_main_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .step  (main_tick),
    .cnt   (main_cnt)
  );

  seq_key_filter #(.SAMPLES(KEY_SAMPLES)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (outs.asleep),
    .sample   (slow_tick),
    .key      (pwr_key),
    .accepted (key_accept)
  );

  seq_fsm #(
    .TW            (TW),
    .DW            (DW),
    .STBY_TICKS    (STBY_TICKS),
    .OSC_TMO_TICKS (OSC_TMO_TICKS),
    .HWRST_TICKS   (HWRST_TICKS),
    .INTRST_TICKS  (INTRST_TICKS),
    .INIT_TICKS    (INIT_TICKS),
    .DSP_CYCLES    (DSP_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .slow_tick (slow_tick),
    .main_tick (main_tick),
    .osc_ready (osc_ready),
    .key_ok    (key_accept),
    .slow_cnt  (slow_cnt),
    .main_cnt  (main_cnt),
    .state_q   (state_q),
    .restart   (restart)
  );

  seq_outdec u_dec (
    .state (state_q),
    .outs  (outs)
  );

  assign standby_en  = outs.standby_en;
  assign ctrl_pwr_en = outs.ctrl_pwr_en;
  assign osc_en      = outs.osc_en;
  assign hw_rst_n    = outs.hw_rst_n;
  assign ctrl_rst_n  = outs.ctrl_rst_n;
  assign dsp_rst_n   = outs.dsp_rst_n;
  assign asleep      = outs.asleep;
  assign boot_go     = outs.boot_go;
  assign fault       = outs.fault;

endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic adapter_ok,
  input logic battery_ok,
  input logic main_tick,
  input logic standby_en,
  input logic ctrl_pwr_en,
  input logic osc_en,
  input logic hw_rst_n,
  input logic ctrl_rst_n,
  input logic dsp_rst_n,
  input logic asleep,
  input logic fault,
  input logic key_ok
);

  assert_off_on_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adapter_ok && !battery_ok) |=> (!standby_en && !osc_en && !dsp_rst_n && !fault));

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!osc_en && !ctrl_rst_n && !dsp_rst_n));

  assert_sleep_osc_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !osc_en);

  assert_hwrst_osc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_en && !hw_rst_n) |-> !osc_en);

  assert_wake_needs_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(asleep) && standby_en) |-> $past(key_ok));

  assert_wake_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(asleep) && standby_en) |-> osc_en);

  assert_dsp_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsp_rst_n) |-> $past(main_tick));

  assert_pwr_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_pwr_en) |-> $past(standby_en));

endmodule

bind pwr_wake_seq pwr_wake_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adapter_ok  (adapter_ok),
  .battery_ok  (battery_ok),
  .main_tick   (main_tick),
  .standby_en  (standby_en),
  .ctrl_pwr_en (ctrl_pwr_en),
  .osc_en      (osc_en),
  .hw_rst_n    (hw_rst_n),
  .ctrl_rst_n  (ctrl_rst_n),
  .dsp_rst_n   (dsp_rst_n),
  .asleep      (asleep),
  .fault       (fault),
  .key_ok      (key_accept)
);

// File: tb/pwr_wake_seq_bench.sv
`timescale 1ns/1ps
module pwr_wake_seq_bench;

  localparam int TP    = 8;     // clk cycles per slow tick
  localparam int STB   = 4;
  localparam int TMO   = 12;
  localparam int HWR   = 5;
  localparam int INR   = 3;
  localparam int INI   = 4;
  localparam int KEYN  = 32;
  localparam int DSPN  = 1024;
  localparam int PLEN  = 160;

  logic clk = 1'b0;
  logic rst_n;
  logic slow_tick;
  logic main_tick;
  logic adapter_ok, battery_ok, pwr_key, osc_ready;
  logic standby_en, ctrl_pwr_en, osc_en, hw_rst_n, ctrl_rst_n, dsp_rst_n;
  logic asleep, boot_go, fault;

  int tdiv;
  int octr;
  int rdy_dly;
  bit rdy_allow;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign main_tick = osc_en;

  // slow tick divider and crystal model
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv      <= 0;
      slow_tick <= 1'b0;
      octr      <= 0;
      osc_ready <= 1'b0;
    end else begin
      tdiv      <= (tdiv + 1) % TP;
      slow_tick <= (tdiv == TP - 1);
      if (!osc_en) begin
        octr      <= 0;
        osc_ready <= 1'b0;
      end else begin
        if (slow_tick) octr <= octr + 1;
        osc_ready <= rdy_allow && (octr >= rdy_dly);
      end
    end
  end

  pwr_wake_seq #(
    .STBY_TICKS(STB), .OSC_TMO_TICKS(TMO), .HWRST_TICKS(HWR),
    .INTRST_TICKS(INR), .INIT_TICKS(INI), .KEY_SAMPLES(KEYN), .DSP_CYCLES(DSPN)
  ) u_pwr_wake_seq (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .main_tick(main_tick),
    .adapter_ok(adapter_ok), .battery_ok(battery_ok), .pwr_key(pwr_key),
    .osc_ready(osc_ready), .standby_en(standby_en), .ctrl_pwr_en(ctrl_pwr_en),
    .osc_en(osc_en), .hw_rst_n(hw_rst_n), .ctrl_rst_n(ctrl_rst_n),
    .dsp_rst_n(dsp_rst_n), .asleep(asleep), .boot_go(boot_go), .fault(fault)
  );

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick_edge();
    for (int g = 0; g < 100; g++) begin
      step();
      if (slow_tick) break;
    end
  endtask

  function automatic int all_off();
    return {standby_en, ctrl_pwr_en, osc_en, hw_rst_n, ctrl_rst_n,
            dsp_rst_n, asleep, boot_go, fault};
  endfunction

  // index of the sample that completes KEYN consecutive highs, or -1
  function automatic int exp_accept(input bit s[PLEN], input int n);
    int run = 0;
    for (int i = 0; i < n; i++) begin
      run = s[i] ? run + 1 : 0;
      if (run >= KEYN) return i;
    end
    return -1;
  endfunction

  task automatic power_off(input string req);
    adapter_ok = 1'b0;
    battery_ok = 1'b0;
    step();
    check(all_off() == 0, req, all_off(), 0);
  endtask

  task automatic bring_up(input bit use_a, input bit use_b, input int d, input bit exact);
    int n;
    bit prev;
    rdy_dly = d;
    rdy_allow = 1'b1;
    pwr_key = 1'b0;
    adapter_ok = use_a;
    battery_ok = use_b;
    step();
    check(standby_en == 1'b1, "R2 standby", standby_en, 1);
    n = 1;
    for (int g = 0; g < 1000; g++) begin step(); if (osc_en) break; n++; end
    check(n > (STB - 1) * TP && n <= STB * TP, "R2 standby-to-osc cycles", n, STB * TP);
    check(ctrl_pwr_en == 1'b1, "R2 ctrl power", ctrl_pwr_en, 1);
    n = 1;
    prev = 1'b0;
    for (int g = 0; g < 1000; g++) begin
      prev = osc_ready;
      step();
      if (!hw_rst_n) break;
      n++;
    end
    check(prev == 1'b1, "R3 ready before hw reset", prev, 1);
    check(osc_en == 1'b0, "R4 osc stopped in hw reset", osc_en, 0);
    if (exact) check(n == TP, "R3 start wait cycles", n, TP);
    n = 1;
    for (int g = 0; g < 1000; g++) begin step(); if (hw_rst_n) break; n++; end
    check(n == HWR * TP, "R4 hw reset cycles", n, HWR * TP);
    check(ctrl_rst_n == 1'b0 && osc_en == 1'b0, "R4 internal reset, osc off",
          {ctrl_rst_n, osc_en}, 0);
    n = 1;
    for (int g = 0; g < 1000; g++) begin step(); if (osc_en) break; n++; end
    check(n == INR * TP, "R4 internal reset cycles", n, INR * TP);
    check(ctrl_rst_n == 1'b1, "R5 ctrl reset released at restart", ctrl_rst_n, 1);
    n = 1;
    for (int g = 0; g < 2000; g++) begin step(); if (asleep) break; n++; end
    if (exact) check(n == (1 + INI) * TP, "R5 restart+init cycles", n, (1 + INI) * TP);
    check(asleep == 1'b1 && osc_en == 1'b0, "R5 sleep with osc off", {asleep, osc_en}, 2);
  endtask

  task automatic sleep_key(input bit s[PLEN], input int n, input string req);
    int obs = -1;
    int k;
    k = exp_accept(s, n);
    for (int i = 0; i <= n; i++) begin
      wait_tick_edge();
      if (!asleep) begin obs = i; break; end
      if (i < n) pwr_key = s[i];
    end
    check(obs == ((k >= 0) ? k + 1 : -1), req, obs, (k >= 0) ? k + 1 : -1);
    if (asleep) begin
      pwr_key = 1'b1;
      for (int g = 0; g < 60 && asleep; g++) wait_tick_edge();
    end
    pwr_key = 1'b0;
  endtask

  task automatic dsp_phase();
    int c;
    check(osc_en == 1'b1 && dsp_rst_n == 1'b0, "R7 wake osc on, dsp held",
          {osc_en, dsp_rst_n}, 2);
    for (int g = 0; g < 2000 && !(slow_tick && osc_ready); g++) step();
    c = 0;
    for (int g = 0; g < 3000; g++) begin step(); c++; if (dsp_rst_n) break; end
    check(c == DSPN + 1, "R8 dsp reset length", c, DSPN + 1);
    check(boot_go == 1'b1, "R8 boot_go", boot_go, 1);
  endtask

  task automatic rand_pattern(output bit s[PLEN], output int n);
    int i = 0;
    int len;
    while (i < PLEN - 1) begin
      len = 5 + ($urandom % 36);
      for (int j = 0; j < len && i < PLEN - 1; j++) begin s[i] = 1'b1; i++; end
      s[i] = 1'b0;
      i++;
    end
    n = PLEN;
  endtask

  initial begin
    bit pat[PLEN];
    int n;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    adapter_ok = 1'b0;
    battery_ok = 1'b0;
    pwr_key = 1'b0;
    rdy_allow = 1'b1;
    rdy_dly = 0;
    repeat (4) step();
    check(all_off() == 0, "R1 outputs in reset", all_off(), 0);
    rst_n = 1'b1;
    repeat (40) step();
    check(all_off() == 0, "R1 no supply stays off", all_off(), 0);

    // run 0: adapter, crystal ready at once, directed broken key run
    bring_up(1'b1, 1'b0, 0, 1'b1);
    for (int i = 0; i < PLEN; i++) pat[i] = (i != 31);
    sleep_key(pat, 70, "R6 31 highs then low then 32 highs");
    dsp_phase();
    power_off("R10 loss from run");

    // runs 1..3: random crystal delay and key patterns
    for (int r = 1; r <= 3; r++) begin
      bring_up(r != 1, r != 2, $urandom % 5, 1'b0);
      rand_pattern(pat, n);
      sleep_key(pat, n, "R6 random key pattern");
      dsp_phase();
      if (r == 3) begin
        adapter_ok = 1'b0;
        repeat (3) step();
        check(boot_go == 1'b1 && standby_en == 1'b1, "R10 one supply left keeps running",
              {boot_go, standby_en}, 3);
      end
      power_off("R10 loss after boot");
    end

    // key held through the start-up sequence is not counted before sleep
    bring_up(1'b1, 1'b0, 0, 1'b0);
    for (int i = 0; i < PLEN; i++) pat[i] = (i >= 10);
    sleep_key(pat, 50, "R6 count starts inside sleep");
    dsp_phase();
    power_off("R10 loss");

    // start-up crystal timeout
    rdy_allow = 1'b0;
    adapter_ok = 1'b1;
    for (int g = 0; g < 1000; g++) begin step(); if (osc_en) break; end
    n = 1;
    for (int g = 0; g < 1000; g++) begin step(); if (fault) break; n++; end
    check(n == TMO * TP, "R9 start timeout cycles", n, TMO * TP);
    check(osc_en == 1'b0 && ctrl_rst_n == 1'b0 && dsp_rst_n == 1'b0, "R9 fault outputs",
          {osc_en, ctrl_rst_n, dsp_rst_n}, 0);
    rdy_allow = 1'b1;
    pwr_key = 1'b1;
    repeat (400) step();
    check(fault == 1'b1 && osc_en == 1'b0, "R9 fault holds", {fault, osc_en}, 2);
    pwr_key = 1'b0;
    power_off("R10 loss clears fault");

    // wake crystal timeout
    bring_up(1'b0, 1'b1, 1, 1'b0);
    rdy_allow = 1'b0;
    for (int i = 0; i < PLEN; i++) pat[i] = 1'b1;
    sleep_key(pat, 40, "R6 continuous press");
    n = 0;
    for (int g = 0; g < 1000; g++) begin if (fault) break; step(); n++; end
    check(fault == 1'b1 && n <= (TMO + 1) * TP, "R9 wake timeout", n, TMO * TP);
    power_off("R10 loss from fault");
    rdy_allow = 1'b1;

    // supply loss at random points of the sequence
    for (int r = 0; r < 4; r++) begin
      rdy_dly = $urandom % 3;
      battery_ok = 1'b1;
      pwr_key = 1'b1;
      repeat (1 + ($urandom % 700)) step();
      pwr_key = 1'b0;
      power_off("R10 random loss");
      repeat (3) step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule